// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Generator

This block sits next to a main interrupt controller and decides when a shared peripheral interrupt should pull a processor out of a low-power state. The vector of shared interrupt lines goes straight through to the downstream controller, combinationally and unchanged, whatever the enable state. Index 0 of the vector is the first shared interrupt. Software-generated and private per-CPU interrupts never enter the block, so they have no enable bits and can never cause a wakeup.

Each CPU has its own bank of 32-bit enable words, one bit per shared interrupt. Software reads and writes these words over a simple memory-mapped register port. A write takes effect at the next clock edge. A read returns the addressed word in the same cycle, so single bits can be updated by read-modify-write. For each CPU the block drives a registered wakeup request. The request is high while any interrupt that this CPU has enabled is active. The number of CPUs and the number of enable words per CPU are parameters. The default is 2 CPUs with 5 words each, which covers 160 interrupts. Other useful sizes are 4 words (128 interrupts) and 7 words with a single CPU (224 interrupts).

Top module: `cpu_wake_gen`

## Requirements
- R1: A synchronous active-low reset clears every enable word of every CPU to zero and drives all wakeup requests low on the following clock edge.
- R2: `irq_out` equals `irq_in` in every cycle, independent of the enable words and of reset.
- R3: The enable word for CPU c, word w, is at byte address c*0x400 + w*4. Bit k of word w enables interrupt 32*w + k, so interrupt n maps to word n>>5 and bit n%32.
- R4: A write with `bus_sel` and `bus_wr` high to an implemented address replaces the whole word at the next rising clock edge. While `bus_sel` is high and the address is implemented, `bus_rdata` shows the current stored word in the same cycle.
- R5: An address is unimplemented if its low two bits are non-zero, its CPU field (address bits above 9) is not below the CPU count, or its word field (bits 9:2) is not below the word count. Reads of an unimplemented address return zero, and writes to it change no stored word.
- R6: At each rising edge outside reset, `wake_req[c]` is loaded with the OR over all interrupts of (`irq_in` AND the enable bits of CPU c). The enable bits used are the values held before any write at that same edge.
- R7: Writing 0xFFFFFFFF to a word enables all 32 of its interrupts, and writing 0x00000000 disables all 32. A CPU's enable bits affect only that CPU's wakeup request.
- R8: `bus_rdata` is zero whenever `bus_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | NUM_BANKS*32 | Shared interrupt lines, index 0 is the first shared interrupt |
| irq_out | output | NUM_BANKS*32 | Unmasked copy of irq_in for the downstream controller |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| wake_req | output | NUM_CPUS | Registered wakeup request per CPU |

## Verification
The case that needs care is a register write and an interrupt that land in the same cycle. If the write enables an interrupt that is already active, the wakeup must ignore the new bit for one edge and follow it from the next. If the write disables the interrupt, the old bit still counts for that one edge. The bench builds this directly: it writes an enable bit in the same cycle the matching line rises, and it writes a mask to an enabled line that is active. The random phase also produces many such overlaps. The bench model judges each one by evaluating the wakeup against the enable words held before the write, and only then applying the write.

// File: rtl/wkg_pkg.sv
package wkg_pkg;
    localparam int WORD_W        = 32;
    localparam int WORD_BYTES    = 4;
    localparam int CPU_STRIDE    = 1024;
    localparam int CPU_SHIFT     = 10;
    localparam int FIELD_W       = 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic               hit;
        logic [FIELD_W-1:0] cpu;
        logic [FIELD_W-1:0] word;
    } acc_dec_t;
endpackage

// File: rtl/wkg_addr_dec.sv
module wkg_addr_dec
    import wkg_pkg::*;
#(
    parameter int NUM_CPUS  = 2,
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_dec_t          dec
);
    localparam int CPU_FIELD_W = ADDR_W - CPU_SHIFT;

    logic [31:0] cpu_ext;
    logic [31:0] word_ext;

    always_comb begin
        cpu_ext  = 32'(addr[ADDR_W-1:CPU_SHIFT]);
        word_ext = 32'(addr[CPU_SHIFT-1:2]);
        dec.cpu  = cpu_ext[FIELD_W-1:0];
        dec.word = word_ext[FIELD_W-1:0];
        dec.hit  = (addr[1:0] == 2'b00)
                 && (cpu_ext  < 32'(NUM_CPUS))
                 && (word_ext < 32'(NUM_BANKS))
                 && (CPU_FIELD_W > 0);
    end
endmodule

// File: rtl/wkg_wake_reduce.sv
module wkg_wake_reduce #(
    parameter int WIDTH = 160
) (
    input  logic [WIDTH-1:0] lines,
    input  logic [WIDTH-1:0] enables,
    output logic             any_hit
);
    always_comb begin
        any_hit = |(lines & enables);
    end
endmodule

// File: rtl/wkg_enable_bank.sv
module wkg_enable_bank
    import wkg_pkg::*;
#(
    parameter int NUM_BANKS = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [FIELD_W-1:0]          wr_word,
    input  word_t                       wr_data,
    input  logic [NUM_BANKS*WORD_W-1:0] irq,
    output logic [NUM_BANKS*WORD_W-1:0] en_flat,
    output logic                        wake
);
    localparam int LINES = NUM_BANKS * WORD_W;

    typedef struct packed {
        logic [NUM_BANKS-1:0][WORD_W-1:0] en;
        logic                             wake;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic        hit_now;

    wkg_wake_reduce #(.WIDTH(LINES)) u_reduce (
        .lines   (irq),
        .enables (st_q.en),
        .any_hit (hit_now)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wake = hit_now;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (wr_en && (wr_word == FIELD_W'(b))) begin
                st_d.en[b] = wr_data;
            end
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign en_flat = st_q.en;
    assign wake    = st_q.wake;
endmodule

// File: rtl/cpu_wake_gen.sv
module cpu_wake_gen
    import wkg_pkg::*;
#(
    parameter int NUM_CPUS  = 2,
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 12,
    localparam int NUM_IRQS = NUM_BANKS * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQS-1:0] irq_in,
    output logic [NUM_IRQS-1:0] irq_out,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic [NUM_CPUS-1:0] wake_req
);
    acc_dec_t                         dec;
    logic [NUM_CPUS-1:0][NUM_IRQS-1:0] en_all;
    logic [NUM_CPUS-1:0]              cpu_wr;

    assign irq_out = irq_in;

    wkg_addr_dec #(
        .NUM_CPUS  (NUM_CPUS),
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        assign cpu_wr[c] = bus_sel && bus_wr && dec.hit
                         && (dec.cpu == FIELD_W'(c));

        wkg_enable_bank #(.NUM_BANKS(NUM_BANKS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cpu_wr[c]),
            .wr_word (dec.word),
            .wr_data (bus_wdata),
            .irq     (irq_in),
            .en_flat (en_all[c]),
            .wake    (wake_req[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bus_sel && dec.hit && (dec.cpu == FIELD_W'(c))
                    && (dec.word == FIELD_W'(b))) begin
                    bus_rdata = en_all[c][b*WORD_W +: WORD_W];
                end
            end
        end
    end
endmodule

// File: rtl/wkg_checker.sv
module wkg_checker #(
    parameter int NUM_CPUS  = 2,
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 12,
    parameter int NUM_IRQS  = NUM_BANKS * 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_IRQS-1:0] irq_in,
    input logic [NUM_IRQS-1:0] irq_out,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [NUM_CPUS-1:0] wake_req
);
    logic [31:0] a_ext;
    logic        mapped;

    always_comb begin
        a_ext  = 32'(bus_addr);
        mapped = (a_ext % 4 == 0)
              && (a_ext / 1024 < 32'(NUM_CPUS))
              && ((a_ext % 1024) / 4 < 32'(NUM_BANKS));
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (wake_req == '0));

    assert_pass_through_R2: assert property (@(posedge clk)
        irq_out == irq_in);

    assert_write_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_sel && bus_wr && mapped) && bus_sel && !bus_wr
         && (bus_addr == $past(bus_addr))) |-> (bus_rdata == $past(bus_wdata)));

    assert_unmapped_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !mapped) |-> (bus_rdata == '0));

    assert_no_spurious_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake_req) |-> $past(|irq_in));

    assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == '0));
endmodule

bind cpu_wake_gen wkg_checker #(
    .NUM_CPUS  (NUM_CPUS),
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .NUM_IRQS  (NUM_IRQS)
) u_wkg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .irq_out   (irq_out),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wake_req  (wake_req)
);

// File: tb/cpu_wake_gen_test.sv
module cpu_wake_gen_test;
    localparam int NC = 2;
    localparam int NB = 5;
    localparam int AW = 12;
    localparam int NI = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] irq_in = '0;
    logic [NI-1:0] irq_out;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] wake_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit armed = 1'b0;

    logic [31:0]   m_en [NC][NB];
    logic [NC-1:0] exp_wake = '0;
    string         wtag = "R6";
    string         rtag = "";

    always #2 clk = ~clk;

    cpu_wake_gen #(.NUM_CPUS(NC), .NUM_BANKS(NB), .ADDR_W(AW)) uut (
        .clk (clk), .rst_n (rst_n), .irq_in (irq_in), .irq_out (irq_out),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .wake_req (wake_req)
    );

    task automatic chk(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit addr_ok(logic [AW-1:0] a);
        int ai = int'(a);
        return (ai % 4 == 0) && (ai / 1024 < NC) && ((ai % 1024) / 4 < NB);
    endfunction

    function automatic logic [31:0] exp_read(logic sel, logic [AW-1:0] a);
        int ai = int'(a);
        if (!sel || !addr_ok(a)) return 32'h0;
        return m_en[ai / 1024][(ai % 1024) / 4];
    endfunction

    function automatic logic [NC-1:0] exp_wake_of(logic [NI-1:0] irq);
        logic [NC-1:0] w = '0;
        for (int c = 0; c < NC; c++)
            for (int n = 0; n < NI; n++)
                if (irq[n] && m_en[c][n >> 5][n % 32]) w[c] = 1'b1;
        return w;
    endfunction

    task automatic cyc(logic r, logic s, logic w, logic [AW-1:0] a,
                       logic [31:0] d, logic [NI-1:0] q);
        string t;
        @(negedge clk);
        if (armed) chk(wake_req === exp_wake, wtag, 256'(wake_req), 256'(exp_wake));
        rst_n = r; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; irq_in = q;
        #1;
        chk(irq_out === irq_in, "R2", 256'(irq_out), 256'(irq_in));
        if (armed && r) begin
            if (rtag != "") t = rtag;
            else if (!s) t = "R8";
            else if (!addr_ok(a)) t = "R5";
            else t = "R4";
            chk(bus_rdata === exp_read(s, a), t, 256'(bus_rdata), 256'(exp_read(s, a)));
        end
        @(posedge clk);
        if (!r) begin
            exp_wake = '0;
            for (int c = 0; c < NC; c++) for (int b = 0; b < NB; b++) m_en[c][b] = '0;
            armed = 1'b1;
        end else begin
            exp_wake = exp_wake_of(q);
            if (s && w && addr_ok(a)) m_en[int'(a) / 1024][(int'(a) % 1024) / 4] = d;
        end
    endtask

    task automatic idle(logic [NI-1:0] q);
        cyc(1'b1, 1'b0, 1'b0, '0, '0, q);
    endtask

    function automatic logic [NI-1:0] one_irq(int n);
        logic [NI-1:0] v = '0;
        v[n] = 1'b1;
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R6 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset, then all words zero and no wake
        cyc(1'b0, 1'b0, 1'b0, '0, '0, '1);
        cyc(1'b0, 1'b0, 1'b0, '0, '0, '1);
        rtag = "R1"; wtag = "R1";
        for (int c = 0; c < NC; c++)
            for (int b = 0; b < NB; b++)
                cyc(1'b1, 1'b1, 1'b0, AW'(c * 1024 + b * 4), '0, '1);
        rtag = ""; wtag = "R6";
        idle('0);

        // R3: cpu1 word3 bit9 is interrupt 105
        cyc(1'b1, 1'b1, 1'b1, AW'(12'h40C), 32'h0000_0200, '0);
        idle(one_irq(105));
        wtag = "R3"; idle('0); wtag = "R6";
        idle(one_irq(104));
        idle('0);

        // R7: all-ones on cpu0 word4, only cpu0 wakes on interrupt 140
        cyc(1'b1, 1'b1, 1'b1, AW'(12'h010), 32'hFFFF_FFFF, '0);
        idle(one_irq(140));
        wtag = "R7"; idle(one_irq(159)); idle('0); wtag = "R6";
        cyc(1'b1, 1'b1, 1'b1, AW'(12'h010), 32'h0000_0000, one_irq(140));
        idle(one_irq(140));
        wtag = "R7"; idle('0); wtag = "R6";

        // R6: enable written in the same cycle the line rises
        cyc(1'b1, 1'b1, 1'b1, AW'(12'h000), 32'h0000_0001, one_irq(0));
        idle(one_irq(0));
        idle('0);

        // R5: unmapped writes ignored, reads zero
        cyc(1'b1, 1'b1, 1'b1, AW'(12'h014), 32'hFFFF_FFFF, '0);
        cyc(1'b1, 1'b1, 1'b1, AW'(12'h801), 32'hFFFF_FFFF, '0);
        cyc(1'b1, 1'b1, 1'b1, AW'(12'h402), 32'hFFFF_FFFF, '0);
        rtag = "R5";
        cyc(1'b1, 1'b1, 1'b0, AW'(12'h014), '0, '0);
        cyc(1'b1, 1'b1, 1'b0, AW'(12'h400), '0, '0);
        rtag = "";
        idle(one_irq(160 - 1));

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            logic [31:0]   d;
            logic [NI-1:0] q = '0;
            int            k = $urandom % 8;
            if (k < 6) a = AW'(($urandom % NC) * 1024 + ($urandom % NB) * 4);
            else if (k == 6) a = AW'(($urandom % NC) * 1024 + (NB + $urandom % (256 - NB)) * 4);
            else a = AW'($urandom);
            case ($urandom % 4)
                0: d = 32'h0;
                1: d = 32'hFFFF_FFFF;
                default: d = $urandom;
            endcase
            for (int j = 0; j < int'($urandom % 3); j++) q[$urandom % NI] = 1'b1;
            cyc(($urandom % 500) != 0, ($urandom % 4) != 0, ($urandom % 2) == 1, a, d, q);
        end
        idle('0);
        idle('0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule